// File: doc/BRIEF.md
# Two-Level Eight-Source Interrupt Arbiter

This block chooses which of eight interrupt sources the processor vectors to next. Each source presents a request line, an enable bit and a one-bit priority level. A source can be taken only when its request and its enable are both set. The arbiter acts only on an instruction-boundary strobe, and only while the global enable is set. It reports the chosen source through a one-cycle take pulse, a 3-bit index, the vector address and a one-hot acknowledge, which the source uses to clear its edge flag.

The block keeps track of nested service on two levels. A request at the high level can pre-empt a service running at the low level. Nothing pre-empts a service running at the high level. A return pulse retires the most recent active level: the high level first if it is active, otherwise the low level. The arbiter does not stack the program counter and does not decode instructions.

The sources are ranked by index, with index 0 polled first. Indices 0 to 7 are: external 0, timer 0, external 1, timer 1, serial, timer 2, external 2, external 3.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is held and after it is released, `take_o` is 0, `ack_o` is 00H, `src_o` is 0 and `vec_o` is 03H.
- R2: A source is taken only at a clock edge where `boundary_i` and `glb_en_i` are both 1. `take_o` goes high in the following cycle and stays high for exactly one cycle.
- R3: A source is eligible only if its `req_i` bit and its `en_i` bit are both 1. A request whose enable is 0 is never taken.
- R4: An eligible source whose `prio_hi_i` bit is 1 (high level) wins over every eligible source whose bit is 0 (low level), whatever their indices.
- R5: Among eligible sources of the same level, the lowest index wins. `src_o` shows the winner and holds that value until the next take.
- R6: `vec_o` equals 03H plus 8 times `src_o`. This gives 03H, 0BH, 13H, 1BH, 23H, 2BH, 33H and 3BH for indices 0 to 7.
- R7: `ack_o` has exactly one bit set, at bit position `src_o`, during the cycle when `take_o` is high. At all other times `ack_o` is 00H.
- R8: While a high-level service is active, no source is taken.
- R9: While a low-level service is active and no high-level service is active, only high-level sources can be taken.
- R10: A `reti_i` pulse clears the high level if it is active, otherwise it clears the low level. A return pulse with no active level has no effect.
- R11: A high-level take during a low-level service leaves both levels active. Two returns are then needed before a low-level source can be taken again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request line for each source |
| en_i | input | 8 | Enable bit for each source |
| prio_hi_i | input | 8 | Level for each source: 1 is high, 0 is low |
| glb_en_i | input | 1 | Global interrupt enable |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle pulse when a source is taken |
| src_o | output | 3 | Index of the last source taken |
| vec_o | output | 8 | Vector address of `src_o` |
| ack_o | output | 8 | One-hot acknowledge to the taken source |

## Verification
The assertions check the following on every cycle:
- A take follows a qualified boundary strobe.
- The taken source was requested and enabled.
- A take never happens during a high-level service.
- A take during a low-level service is always a high-level one.
- A pending high-level request always beats a low-level one.
- The acknowledge is one-hot and matches the index.

Some behaviour is a matter of sequence and only the bench scenarios can show it. This covers the exact order in which return pulses retire nested levels, the vector values, lowest-index tie breaking, and the effect of a return when no level is active.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned VEC_BASE = 3;
  localparam int unsigned VEC_STEP = 8;

  // vector address for a source index
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    v = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx);
    return v;
  endfunction

endpackage

// File: rtl/irq_src_qualify.sv
// Masks raw requests by enable and by the current nesting state, splitting
// the survivors into high-level and low-level candidate vectors.
module irq_src_qualify #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] prio_hi_i,
  input  logic         hi_act_i,
  input  logic         lo_act_i,
  output logic [N-1:0] cand_hi_o,
  output logic [N-1:0] cand_lo_o
);

  logic [N-1:0] elig;

  always_comb begin
    elig = req_i & en_i;
    cand_hi_o = '0;
    cand_lo_o = '0;
    if (!hi_act_i) begin
      cand_hi_o = elig & prio_hi_i;
      if (!lo_act_i) begin
        cand_lo_o = elig & ~prio_hi_i;
      end
    end
  end

endmodule

// File: rtl/irq_fixed_pick.sv
// Fixed-order selector: the lowest set index wins.
module irq_fixed_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign onehot_o[g] = cand_i[g] & ~seen[g];
      assign seen[g+1]   = seen[g] | cand_i[g];
    end
  endgenerate

  assign valid_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/irq_nest_track.sv
// Two-level service tracker. A return retires high first, then low.
// A push in the same cycle applies after the pop.
module irq_nest_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_i,
  input  logic push_hi_i,
  input  logic push_lo_i,
  output logic hi_act_o,
  output logic lo_act_o
);

  logic hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (pop_i) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (push_hi_i) hi_d = 1'b1;
    if (push_lo_i) lo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_act_o = hi_q;
  assign lo_act_o = lo_q;

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic               glb_en_i,
  input  logic               boundary_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   src_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] ack_o
);

  logic               hi_act, lo_act;
  logic [NUM_SRC-1:0] cand_hi, cand_lo, oh_hi, oh_lo;
  logic               v_hi, v_lo;
  logic [IDX_W-1:0]   i_hi, i_lo;

  logic               fire;
  logic               win_is_hi;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_SRC-1:0] win_oh;

  logic               take_q, take_d;
  logic [IDX_W-1:0]   src_q, src_d;
  logic [NUM_SRC-1:0] ack_q, ack_d;

  irq_src_qualify #(.N(NUM_SRC)) u_qual (
    .req_i     (req_i),
    .en_i      (en_i),
    .prio_hi_i (prio_hi_i),
    .hi_act_i  (hi_act),
    .lo_act_i  (lo_act),
    .cand_hi_o (cand_hi),
    .cand_lo_o (cand_lo)
  );

  irq_fixed_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick_hi (
    .cand_i   (cand_hi),
    .valid_o  (v_hi),
    .idx_o    (i_hi),
    .onehot_o (oh_hi)
  );

  irq_fixed_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick_lo (
    .cand_i   (cand_lo),
    .valid_o  (v_lo),
    .idx_o    (i_lo),
    .onehot_o (oh_lo)
  );

  // the high level always overrides the low level
  always_comb begin
    win_is_hi = v_hi;
    win_idx   = v_hi ? i_hi  : i_lo;
    win_oh    = v_hi ? oh_hi : oh_lo;
    fire      = boundary_i & glb_en_i & (v_hi | v_lo);
  end

  irq_nest_track u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_i     (reti_i),
    .push_hi_i (fire & win_is_hi),
    .push_lo_i (fire & ~win_is_hi),
    .hi_act_o  (hi_act),
    .lo_act_o  (lo_act)
  );

  always_comb begin
    take_d = fire;
    ack_d  = fire ? win_oh : '0;
    src_d  = src_q;
    if (fire) src_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= '0;
      ack_q  <= '0;
    end else begin
      take_q <= take_d;
      src_q  <= src_d;
      ack_q  <= ack_d;
    end
  end

  assign take_o = take_q;
  assign src_o  = src_q;
  assign ack_o  = ack_q;
  assign vec_o  = vec_of(src_q);

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] prio_hi_i,
  input logic               glb_en_i,
  input logic               boundary_i,
  input logic               take_o,
  input logic [IDX_W-1:0]   src_o,
  input logic [NUM_SRC-1:0] ack_o,
  input logic               hi_act,
  input logic               lo_act
);

  p_take_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i && glb_en_i));

  p_take_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(req_i & en_i) & ack_o) != '0));

  p_high_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ($past(req_i & en_i & prio_hi_i) != '0) && !$past(hi_act))
      |-> (($past(prio_hi_i) & ack_o) != '0));

  p_ack_matches_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ack_o[src_o]);

  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones(ack_o) == 1));

  p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (ack_o == '0));

  p_high_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !$past(hi_act));

  p_low_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(lo_act)) |-> (($past(prio_hi_i) & ack_o) != '0));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .en_i       (en_i),
  .prio_hi_i  (prio_hi_i),
  .glb_en_i   (glb_en_i),
  .boundary_i (boundary_i),
  .take_o     (take_o),
  .src_o      (src_o),
  .ack_o      (ack_o),
  .hi_act     (hi_act),
  .lo_act     (lo_act)
);

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req, en, pri;
  logic       glb, bnd, reti;
  logic       take;
  logic [2:0] src;
  logic [7:0] vec, ack;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit run_cmp = 0;

  always #5 clk = ~clk;

  irq_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .prio_hi_i(pri),
    .glb_en_i(glb), .boundary_i(bnd), .reti_i(reti),
    .take_o(take), .src_o(src), .vec_o(vec), .ack_o(ack)
  );

  // behavioural reference
  bit m_hi, m_lo, m_take;
  int m_src;
  bit nh, nl;
  int found;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_take = 0; m_src = 0;
    end else begin
      nh = m_hi; nl = m_lo;
      if (reti) begin
        if (nh) nh = 0; else nl = 0;
      end
      m_take = 0;
      found = -1;
      if (bnd && glb && !m_hi) begin
        for (int i = 0; i < 8; i++)
          if (found < 0 && req[i] && en[i] && pri[i]) found = i;
        if (found < 0 && !m_lo)
          for (int i = 0; i < 8; i++)
            if (found < 0 && req[i] && en[i] && !pri[i]) found = i;
      end
      if (found >= 0) begin
        m_take = 1;
        m_src = found;
        if (pri[found]) nh = 1; else nl = 1;
      end
      m_hi = nh; m_lo = nl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(take == m_take, "R2 take", int'(take), int'(m_take));
      chk(int'(src) == m_src, "R5 src", int'(src), m_src);
      chk(int'(vec) == 3 + 8 * m_src, "R6 vec", int'(vec), 3 + 8 * m_src);
      chk(ack == (m_take ? 8'(1 << m_src) : 8'h00), "R7 ack", int'(ack),
          m_take ? (1 << m_src) : 0);
    end
  end

  task automatic cyc(input logic [7:0] r, input logic [7:0] e, input logic [7:0] p,
                     input logic g, input logic b, input logic rt);
    @(negedge clk);
    req = r; en = e; pri = p; glb = g; bnd = b; reti = rt;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_take(input int idx, input string tag);
    chk(take == 1'b1, tag, int'(take), 1);
    chk(int'(src) == idx, tag, int'(src), idx);
    chk(int'(vec) == 3 + 8 * idx, tag, int'(vec), 3 + 8 * idx);
  endtask

  task automatic expect_none(input string tag);
    chk(take == 1'b0 && ack == 8'h00, tag, int'(take), 0);
  endtask

  initial begin
    rst_n = 0;
    req = 0; en = 0; pri = 0; glb = 0; bnd = 0; reti = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(take == 0 && ack == 0 && src == 0 && vec == 8'h03, "R1 reset", int'(vec), 3);
    @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    #1;
    chk(take == 0 && ack == 0 && src == 0 && vec == 8'h03, "R1 after release", int'(vec), 3);

    // R2: no strobe, then strobe without global enable
    cyc(8'h04, 8'hFF, 8'h00, 1, 0, 0); expect_none("R2 no boundary");
    cyc(8'h04, 8'hFF, 8'h00, 0, 1, 0); expect_none("R2 global off");
    // R3: disabled source ignored
    cyc(8'h04, 8'hFB, 8'h00, 1, 1, 0); expect_none("R3 disabled");
    // R5: lowest index among low level
    cyc(8'h0C, 8'hFF, 8'h00, 1, 1, 0); expect_take(2, "R5 tie break");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 0); expect_none("R2 single pulse");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    // R4: high level at index 7 beats low at index 0
    cyc(8'h81, 8'hFF, 8'h80, 1, 1, 0); expect_take(7, "R4 high wins");
    // R8: nothing during high service
    cyc(8'h01, 8'hFF, 8'h01, 1, 1, 0); expect_none("R8 high blocks");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    // R9/R11 nesting
    cyc(8'h02, 8'hFF, 8'h00, 1, 1, 0); expect_take(1, "R9 low start");
    cyc(8'h22, 8'hFF, 8'h00, 1, 1, 0); expect_none("R9 low blocks low");
    cyc(8'h40, 8'hFF, 8'h40, 1, 1, 0); expect_take(6, "R11 preempt");
    cyc(8'h01, 8'hFF, 8'h01, 1, 1, 0); expect_none("R11 high blocks");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h08, 8'hFF, 8'h08, 1, 1, 0); expect_take(3, "R10 low still active");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h01, 8'hFF, 8'h00, 1, 1, 0); expect_none("R10 low remains");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h10, 8'hFF, 8'h00, 1, 1, 0); expect_take(4, "R10 idle return harmless");
    chk(ack == 8'h10, "R7 ack bit", int'(ack), 8'h10);
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h20, 8'hFF, 8'h00, 1, 1, 0); expect_take(5, "R6 vector 2B");
    cyc(8'h00, 8'hFF, 8'h00, 1, 0, 1);
    cyc(8'h00, 8'hFF, 8'h00, 0, 0, 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule